// File: doc/BRIEF.md
# Broadcast Order Signature Checker

This block watches the broadcast coherence requests that each node of a snooping multiprocessor receives, and confirms that all nodes saw the same requests in the same order. Every node lane folds each request it accepts into its own running signature. The fold is an order-sensitive linear-feedback step mixed with a hash of the address, the request kind and the source node. The lanes are compared in logical time: a boundary falls once every lane has accepted a fixed number of requests, not after a number of clock cycles.

At a boundary the central compare unit tests every lane's signature against lane 0. It then reloads all lanes with a common nonzero seed and clears their counts. If any lane disagrees, the block raises a one-cycle error pulse with a mask of the lanes that differ. The system uses this pulse as a request to roll back to a checkpoint. Each lane's input is a valid/ready stream. A lane that reaches the boundary before the others drops ready and holds its final signature until the compare has taken place. The sender must keep valid, address, kind and source steady while ready is low. A request is taken only on a cycle where valid and ready are both high.

Top module: `order_sig_checker`

## Requirements
- R1: A lane's signature changes only on a cycle where its valid and ready are both high, and it becomes step(sig) XOR hash(request).
- R2: step(s) shifts s left by one, fills bit 0 with zero, and XORs in the polynomial POLY (default 0x04C11DB7) when the bit shifted out of the top was 1.
- R3: hash(request) XOR-folds the address into SIG_W bits (address bit i lands on bit i mod SIG_W) and XORs in the concatenation {kind, source}, aligned so that its top bit is signature bit SIG_W-1.
- R4: A request whose address, kind and source are all zero still changes the signature. Two different requests taken in swapped order give a different final signature.
- R5: After a lane has accepted EPOCH_LEN requests, its ready stays low until the next compare. A valid offered during that time is ignored.
- R6: The compare happens on the first clock edge at which every lane holds EPOCH_LEN requests. On that edge all signatures reload SEED, all counts clear, and every ready is high in the following cycle.
- R7: In the cycle after the compare, err_pulse is high for exactly one cycle if any lane's signature differed from lane 0. err_mask then has bit n set for each differing lane n, and bit 0 is always clear.
- R8: err_pulse and err_mask stay zero at every other time, including an epoch with no disagreement and the cycles before a boundary.
- R9: A synchronous reset loads SEED into every signature, clears every count and both error outputs, and leaves every ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | N_NODES | Per-lane request valid |
| req_ready | output | N_NODES | Per-lane ready; low once the lane has filled its epoch |
| req_addr | input | N_NODES*ADDR_W | Per-lane request address; lane n is at bits n*ADDR_W and up |
| req_kind | input | N_NODES*KIND_W | Per-lane request kind code |
| req_src | input | N_NODES*SRC_W | Per-lane source node id of the request |
| err_pulse | output | 1 | One-cycle rollback request after a disagreeing compare |
| err_mask | output | N_NODES | Lanes whose signature differed from lane 0 |

## Verification
The bench swaps two adjacent requests in one lane. A checker built on plain address addition would stay silent on that swap. It also moves an all-zero request from the head of one lane's stream to the tail, which an additive or zero-blind update would also miss. One lane is run far ahead of the others while it keeps offering garbage. A design that failed to freeze that lane, or that compared early, would flag it or pulse too soon. The bench corrupts lane 0 itself, which a mask built against the wrong reference would get wrong. It places a clean epoch directly after a failing one and resets in the middle of an epoch, to catch a missing seed reload or a count that was not cleared.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_READ_SHARED = 3'd0,
    KIND_READ_EXCL   = 3'd1,
    KIND_UPGRADE     = 3'd2,
    KIND_WRITEBACK   = 3'd3,
    KIND_INVALIDATE  = 3'd4
  } req_kind_e;

  localparam logic [31:0] DEF_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] DEF_SEED = 32'h1D2B_3C4F;
endpackage

// File: rtl/osc_sig_mix.sv
module osc_sig_mix #(
  parameter int SIG_W = 32,
  parameter int ADDR_W = 32,
  parameter int KIND_W = 3,
  parameter int SRC_W = 4,
  parameter logic [SIG_W-1:0] POLY = '0
) (
  input  logic [SIG_W-1:0]  sig_cur,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KIND_W-1:0] kind,
  input  logic [SRC_W-1:0]  src,
  output logic [SIG_W-1:0]  sig_nxt
);
  localparam int TAG_W = KIND_W + SRC_W;

  logic [SIG_W-1:0] stepped;
  logic [SIG_W-1:0] folded;
  logic [SIG_W-1:0] tag_pos;
  logic [TAG_W-1:0] tag;

  // Galois-form shift: feedback taps applied when the top bit leaves
  always_comb begin
    stepped = {sig_cur[SIG_W-2:0], 1'b0} ^ ({SIG_W{sig_cur[SIG_W-1]}} & POLY);
  end

  // Address wider than the signature wraps around onto the low bits
  always_comb begin
    folded = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      folded[i % SIG_W] = folded[i % SIG_W] ^ addr[i];
    end
  end

  assign tag = {kind, src};

  always_comb begin
    tag_pos = '0;
    for (int j = 0; j < TAG_W; j++) begin
      tag_pos[SIG_W-TAG_W+j] = tag[j];
    end
  end

  assign sig_nxt = stepped ^ folded ^ tag_pos;
endmodule

// File: rtl/osc_node_lane.sv
module osc_node_lane #(
  parameter int SIG_W = 32,
  parameter int ADDR_W = 32,
  parameter int KIND_W = 3,
  parameter int SRC_W = 4,
  parameter int EPOCH_LEN = 3000,
  parameter logic [SIG_W-1:0] POLY = '0,
  parameter logic [SIG_W-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [SRC_W-1:0]  in_src,
  input  logic              reload,
  output logic              full,
  output logic [SIG_W-1:0]  sig
);
  localparam int CNT_W = $clog2(EPOCH_LEN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(EPOCH_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [SIG_W-1:0] sig_q;
  logic [SIG_W-1:0] sig_d;
  logic             take;

  osc_sig_mix #(
    .SIG_W(SIG_W), .ADDR_W(ADDR_W), .KIND_W(KIND_W), .SRC_W(SRC_W), .POLY(POLY)
  ) u_mix (
    .sig_cur(sig_q),
    .addr   (in_addr),
    .kind   (in_kind),
    .src    (in_src),
    .sig_nxt(sig_d)
  );

  assign full     = (cnt_q == LIMIT);
  assign in_ready = !full;
  assign take     = in_valid && in_ready;
  assign sig      = sig_q;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt_q <= '0;
      sig_q <= SEED;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      sig_q <= sig_d;
    end
  end
endmodule

// File: rtl/osc_epoch_cmp.sv
module osc_epoch_cmp #(
  parameter int N_NODES = 16,
  parameter int SIG_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_NODES-1:0]         lane_full,
  input  logic [N_NODES*SIG_W-1:0]   lane_sig,
  output logic                       boundary,
  output logic                       err_pulse,
  output logic [N_NODES-1:0]         err_mask
);
  logic [N_NODES-1:0] diff;

  assign boundary = &lane_full;

  assign diff[0] = 1'b0;
  for (genvar n = 1; n < N_NODES; n++) begin : g_diff
    assign diff[n] = lane_sig[n*SIG_W +: SIG_W] != lane_sig[0 +: SIG_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_mask  <= '0;
    end else if (boundary) begin
      err_pulse <= |diff;
      err_mask  <= diff;
    end else begin
      err_pulse <= 1'b0;
      err_mask  <= '0;
    end
  end
endmodule

// File: rtl/order_sig_checker.sv
module order_sig_checker #(
  parameter int N_NODES = 16,
  parameter int SIG_W = 32,
  parameter int ADDR_W = 32,
  parameter int KIND_W = osc_pkg::KIND_W,
  parameter int SRC_W = 4,
  parameter int EPOCH_LEN = 3000,
  parameter logic [SIG_W-1:0] POLY = SIG_W'(osc_pkg::DEF_POLY),
  parameter logic [SIG_W-1:0] SEED = SIG_W'(osc_pkg::DEF_SEED)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_NODES-1:0]          req_valid,
  output logic [N_NODES-1:0]          req_ready,
  input  logic [N_NODES*ADDR_W-1:0]   req_addr,
  input  logic [N_NODES*KIND_W-1:0]   req_kind,
  input  logic [N_NODES*SRC_W-1:0]    req_src,
  output logic                        err_pulse,
  output logic [N_NODES-1:0]          err_mask
);
  logic [N_NODES-1:0]       lane_full;
  logic [N_NODES*SIG_W-1:0] lane_sig;
  logic                     boundary;

  for (genvar n = 0; n < N_NODES; n++) begin : g_lane
    osc_node_lane #(
      .SIG_W(SIG_W), .ADDR_W(ADDR_W), .KIND_W(KIND_W), .SRC_W(SRC_W),
      .EPOCH_LEN(EPOCH_LEN), .POLY(POLY), .SEED(SEED)
    ) u_lane (
      .clk     (clk),
      .rst     (rst),
      .in_valid(req_valid[n]),
      .in_ready(req_ready[n]),
      .in_addr (req_addr[n*ADDR_W +: ADDR_W]),
      .in_kind (req_kind[n*KIND_W +: KIND_W]),
      .in_src  (req_src[n*SRC_W +: SRC_W]),
      .reload  (boundary),
      .full    (lane_full[n]),
      .sig     (lane_sig[n*SIG_W +: SIG_W])
    );
  end

  osc_epoch_cmp #(.N_NODES(N_NODES), .SIG_W(SIG_W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .lane_full(lane_full),
    .lane_sig (lane_sig),
    .boundary (boundary),
    .err_pulse(err_pulse),
    .err_mask (err_mask)
  );
endmodule

// File: rtl/order_sig_checker_sva.sv
module order_sig_checker_sva #(
  parameter int N_NODES = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [N_NODES-1:0] req_ready,
  input logic               err_pulse,
  input logic [N_NODES-1:0] err_mask
);
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);

  a_r7_mask_with_pulse: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_mask != '0));

  a_r8_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    !err_pulse |-> (err_mask == '0));

  a_r7_lane0_clear: assert property (@(posedge clk) disable iff (rst)
    !err_mask[0]);

  a_r6_ready_after_compare: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (&req_ready));

  a_r9_reset_ready: assert property (@(posedge clk)
    rst |=> (&req_ready && !err_pulse));

  for (genvar n = 0; n < N_NODES; n++) begin : g_hold
    a_r5_frozen_until_all: assert property (@(posedge clk) disable iff (rst)
      !req_ready[n] |=> (!req_ready[n] || (&req_ready)));
  end
endmodule

bind order_sig_checker order_sig_checker_sva #(.N_NODES(N_NODES)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .err_pulse(err_pulse),
  .err_mask (err_mask)
);

// File: tb/sim_order_sig_checker.sv
`timescale 1ns/1ps
module sim_order_sig_checker;
  localparam int N = 4;
  localparam int E = 16;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [31:0] SEED = 32'h1D2B_3C4F;

  logic clk = 0;
  logic rst = 1;
  logic [N-1:0] req_valid = '0;
  logic [N-1:0] req_ready;
  logic [N*32-1:0] req_addr = '0;
  logic [N*3-1:0] req_kind = '0;
  logic [N*4-1:0] req_src = '0;
  logic err_pulse;
  logic [N-1:0] err_mask;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] s_addr [N][E];
  logic [2:0]  s_kind [N][E];
  logic [3:0]  s_src  [N][E];

  always #2 clk = ~clk;

  order_sig_checker #(.N_NODES(N), .EPOCH_LEN(E)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_src(req_src),
    .err_pulse(err_pulse), .err_mask(err_mask)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 step and R3 hash, written from the requirement text
  function automatic logic [31:0] m_next(logic [31:0] s, logic [31:0] a, logic [2:0] k, logic [3:0] r);
    logic [31:0] st;
    st = {s[30:0], 1'b0};
    if (s[31]) st = st ^ POLY;
    return st ^ a ^ ({25'd0, k, r} << 25);
  endfunction

  function automatic logic [N-1:0] m_mask();
    logic [31:0] sg [N];
    logic [N-1:0] m;
    for (int n = 0; n < N; n++) begin
      sg[n] = SEED;
      for (int i = 0; i < E; i++) sg[n] = m_next(sg[n], s_addr[n][i], s_kind[n][i], s_src[n][i]);
    end
    m = '0;
    for (int n = 1; n < N; n++) m[n] = (sg[n] != sg[0]);
    return m;
  endfunction

  task automatic fill_same();
    for (int i = 0; i < E; i++) begin
      logic [31:0] a;
      logic [2:0] k;
      logic [3:0] r;
      a = $urandom; k = 3'($urandom); r = 4'($urandom);
      for (int n = 0; n < N; n++) begin
        s_addr[n][i] = a; s_kind[n][i] = k; s_src[n][i] = r;
      end
    end
  endtask

  // stall_pct applies to every lane except fast_lane; a full fast_lane keeps offering garbage
  task automatic run_epoch(input string req, input int stall_pct, input int fast_lane);
    int idx [N];
    logic [N-1:0] exp_mask;
    logic early;
    logic frozen_bad;
    bit done;
    exp_mask = m_mask();
    early = 0; frozen_bad = 0;
    for (int n = 0; n < N; n++) idx[n] = 0;
    forever begin
      @(negedge clk);
      if (err_pulse) early = 1;
      done = 1;
      for (int n = 0; n < N; n++) if (idx[n] < E) done = 0;
      for (int n = 0; n < N; n++) begin
        if (idx[n] >= E) begin
          if (req_ready[n]) frozen_bad = 1;
          req_valid[n] = (n == fast_lane);
          req_addr[n*32 +: 32] = $urandom;
        end else if (req_ready[n] && (n == fast_lane || int'($urandom % 100) >= stall_pct)) begin
          req_valid[n] = 1;
          req_addr[n*32 +: 32] = s_addr[n][idx[n]];
          req_kind[n*3 +: 3] = s_kind[n][idx[n]];
          req_src[n*4 +: 4] = s_src[n][idx[n]];
          idx[n]++;
        end else begin
          req_valid[n] = 0;
        end
      end
      if (done) break;
    end
    check({req, " R8 no pulse before boundary"}, 64'(early), 64'd0);
    check({req, " R5 full lane ready low"}, 64'(frozen_bad), 64'd0);
    @(negedge clk);
    req_valid = '0;
    check({req, " R7 pulse"}, 64'(err_pulse), 64'(exp_mask != '0));
    check({req, " R7 mask"}, 64'(err_mask), 64'(exp_mask));
    check({req, " R6 ready after compare"}, 64'(req_ready), 64'({N{1'b1}}));
    @(negedge clk);
    check({req, " R7 R8 pulse one cycle"}, 64'(err_pulse), 64'd0);
  endtask

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] t;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 reset ready", 64'(req_ready), 64'({N{1'b1}}));
    check("R9 reset pulse", 64'(err_pulse), 64'd0);
    check("R9 reset mask", 64'(err_mask), 64'd0);

    // R1 R6: identical streams, no stalls
    fill_same();
    run_epoch("identical", 0, -1);

    // R4 order: lane 2 swaps two adjacent requests
    fill_same();
    s_addr[2][4] = 32'hAAAA_0001; s_addr[2][5] = 32'h5555_0002;
    for (int n = 0; n < N; n++) if (n != 2) begin
      s_addr[n][4] = 32'h5555_0002; s_addr[n][5] = 32'hAAAA_0001;
      s_kind[n][4] = s_kind[2][5]; s_kind[n][5] = s_kind[2][4];
      s_src[n][4] = s_src[2][5]; s_src[n][5] = s_src[2][4];
    end
    check("R4 swap model differs", 64'(m_mask()), 64'(4'b0100));
    run_epoch("R4 swap", 20, -1);

    // R6: clean epoch right after a failing one needs the seed reload
    fill_same();
    run_epoch("R6 reload", 10, -1);

    // R4 zero: all-zero request at head for lanes 0..2, at tail for lane 3
    fill_same();
    for (int n = 0; n < N; n++) begin
      s_addr[n][0] = 0; s_kind[n][0] = 0; s_src[n][0] = 0;
    end
    for (int i = 0; i < E - 1; i++) begin
      s_addr[3][i] = s_addr[0][i+1]; s_kind[3][i] = s_kind[0][i+1]; s_src[3][i] = s_src[0][i+1];
    end
    s_addr[3][E-1] = 0; s_kind[3][E-1] = 0; s_src[3][E-1] = 0;
    check("R4 zero model differs", 64'(m_mask()), 64'(4'b1000));
    run_epoch("R4 zero", 0, -1);

    // R5: lane 1 runs ahead and keeps offering garbage while frozen
    fill_same();
    run_epoch("R5 ahead", 70, 1);

    // R7: lane 0 corrupted, every other lane is flagged
    fill_same();
    s_addr[0][7] = s_addr[0][7] ^ 32'h0000_0100;
    run_epoch("R7 lane0 bad", 30, -1);

    // R9: reset in the middle of an epoch, then a clean epoch
    fill_same();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      req_valid = '1;
      for (int n = 0; n < N; n++) req_addr[n*32 +: 32] = 32'(n * 77 + i);
    end
    @(negedge clk);
    req_valid = '0;
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    check("R9 mid-epoch reset ready", 64'(req_ready), 64'({N{1'b1}}));
    run_epoch("R9 after reset", 15, -1);

    // R1 random stalls, random corruption
    for (int e = 0; e < 8; e++) begin
      fill_same();
      if ($urandom % 2 == 1) begin
        int ln;
        int pos;
        ln = int'($urandom % N);
        pos = int'($urandom % E);
        t = $urandom | 32'h1;
        s_addr[ln][pos] = s_addr[ln][pos] ^ t;
      end
      run_epoch("R1 random", 40, -1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule